// File: doc/BRIEF.md
# Dual-Port Shared Memory with Semaphore Flags

This block is a two-port byte memory with a separate bank of hardware semaphore flags. Each port has two active-low selects. One opens the RAM space: a 4096 x 8 array with a 12-bit address. The other opens the flag space: eight one-bit tokens that arbitrate a shared resource between the two sides. A read/write strobe and an output enable complete the per-port controls. A per-port decoder turns those controls into one of three actions: RAM access, flag access, or standby. Asserting both selects together is a fault. The decoder reports it and refuses the access.

The two ports run from one clock and are fully independent. Both may read or write in the same cycle. Clashes on the same RAM byte are resolved deterministically. A flag is claimed by writing 0 to its data bit 0 and released by writing 1. A claim made by the side that does not hold the flag is queued until the holder releases it. A flag reads back as all zeros on the side that holds it and as all ones on every other side. Read results are registered and appear one clock after the request is sampled, together with a drive-enable that stands in for the pad's output enable.

Top module: `dpm_shared_mem`

## Requirements
- R1: With both selects high (standby), the port drives nothing: rdata_en is 0 and rdata is 0 on the next cycle, and neither the RAM nor a flag changes.
- R2: With ce_n low, sem_n high and rw_n low, the data byte is written to the RAM at the 12-bit address.
- R3: With ce_n low, sem_n high, rw_n high and oe_n low, the stored byte appears on rdata with rdata_en high one clock later.
- R4: With oe_n high, rdata_en is 0 and rdata is 0 on the next cycle, even when the port is selected for a read.
- R5: With ce_n high, sem_n low and rw_n low, address bits [2:0] select a flag and only wdata bit 0 is used. Writing 0 claims a free flag; the other data bits and the upper address bits have no effect.
- R6: With ce_n high, sem_n low, rw_n high and oe_n low, rdata one clock later is 8'h00 if this port holds the selected flag and 8'hFF otherwise. The value is taken from the flag state before any write sampled in the same cycle.
- R7: A claim by the side not holding a flag is queued. When the holder writes 1, a queued claim receives the flag; if none is queued, the flag becomes free. Writing 1 from the non-holding side withdraws its queued claim.
- R8: If both ports claim the same free flag in the same cycle, the left port receives it; no flag ever reads 8'h00 on both sides at once.
- R9: With both selects low, sel_err is 1 on the next cycle, nothing is written to the RAM or the flags, and rdata_en stays 0.
- R10: If both ports write the same RAM address in the same cycle, the left port's byte is stored.
- R11: A RAM read of an address that the other port writes in the same cycle returns the newly written byte.
- R12: After reset, every flag is free, and every port shows rdata_en, sel_err and rdata at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_ce_n | input | 1 | Left RAM select, active low |
| l_sem_n | input | 1 | Left flag-space select, active low |
| l_rw_n | input | 1 | Left strobe: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | 12 | Left address (bits [2:0] pick a flag) |
| l_wdata | input | 8 | Left write byte |
| l_rdata | output | 8 | Left read byte, 0 when not driven |
| l_rdata_en | output | 1 | Left data drive enable |
| l_sel_err | output | 1 | Left both-selects fault |
| r_ce_n | input | 1 | Right RAM select, active low |
| r_sem_n | input | 1 | Right flag-space select, active low |
| r_rw_n | input | 1 | Right strobe: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 12 | Right address (bits [2:0] pick a flag) |
| r_wdata | input | 8 | Right write byte |
| r_rdata | output | 8 | Right read byte, 0 when not driven |
| r_rdata_en | output | 1 | Right data drive enable |
| r_sel_err | output | 1 | Right both-selects fault |

## Verification
Every result of this block appears exactly one clock after the edge that samples the request: read bytes, the drive enable and the fault flag. Writes take effect at that same edge, so the first cycle that can observe them is the following one. The bench sets both ports after a falling edge and lets one rising edge pass. At the next falling edge it compares all outputs against a behavioural model, whose read values are computed from the state before that cycle's writes are applied. Flag arbitration, same-cycle write races and read-during-write forwarding are exercised in directed sequences and again in a mixed pseudo-random run.

// File: rtl/dpm_pkg.sv
`timescale 1ns/1ps
package dpm_pkg;

    typedef enum logic [1:0] {
        OWN_FREE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } sem_owner_e;

    // Decoded intent of one port for the current cycle
    typedef struct packed {
        logic ram_wr;
        logic ram_rd;
        logic sem_wr;
        logic sem_rd;
        logic drive;
        logic bad;
    } port_req_t;

    // Registered per-port output control (index 0 left, 1 right)
    typedef struct packed {
        logic [1:0] drive;
        logic [1:0] from_sem;
        logic [1:0] err;
    } out_ctl_t;

endpackage

// File: rtl/dpm_port_decode.sv
`timescale 1ns/1ps
module dpm_port_decode
    import dpm_pkg::*;
(
    input  logic      ce_n,
    input  logic      sem_n,
    input  logic      rw_n,
    input  logic      oe_n,
    output port_req_t req
);

    logic ram_hit;
    logic sem_hit;

    always_comb begin
        ram_hit    = !ce_n && sem_n;
        sem_hit    = ce_n && !sem_n;
        req.ram_wr = ram_hit && !rw_n;
        req.ram_rd = ram_hit && rw_n;
        req.sem_wr = sem_hit && !rw_n;
        req.sem_rd = sem_hit && rw_n;
        req.drive  = (ram_hit || sem_hit) && rw_n && !oe_n;
        req.bad    = !ce_n && !sem_n;
    end

endmodule

// File: rtl/dpm_ram_core.sv
`timescale 1ns/1ps
module dpm_ram_core #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           wr_en,
    input  logic [1:0]           rd_en,
    input  logic [1:0][AW-1:0]   addr,
    input  logic [1:0][DW-1:0]   wdata,
    output logic [1:0][DW-1:0]   rdata
);

    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [1:0][DW-1:0] rd;
    } ram_st_t;

    logic [DW-1:0] mem [DEPTH];
    ram_st_t       st_d, st_q;
    logic [1:0]    wr_commit;
    logic          same_addr;

    // Left port wins a same-address write race
    always_comb begin
        same_addr    = (addr[0] == addr[1]);
        wr_commit[0] = wr_en[0];
        wr_commit[1] = wr_en[1] && !(wr_en[0] && same_addr);
    end

    // Read path with forwarding of the opposite port's same-cycle write
    always_comb begin
        st_d = st_q;
        for (int p = 0; p < 2; p++) begin
            if (rd_en[p]) begin
                if (wr_en[1-p] && same_addr) begin
                    st_d.rd[p] = wdata[1-p];
                end else begin
                    st_d.rd[p] = mem[addr[p]];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < 2; p++) begin
            if (wr_commit[p]) begin
                mem[addr[p]] <= wdata[p];
            end
        end
    end

    assign rdata = st_q.rd;

endmodule

// File: rtl/dpm_sem_bank.sv
`timescale 1ns/1ps
module dpm_sem_bank
    import dpm_pkg::*;
#(
    parameter int NFLAGS = 8,
    parameter int DW     = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           wr_en,
    input  logic [1:0]           rd_en,
    input  logic [1:0][$clog2(NFLAGS)-1:0] idx,
    input  logic [1:0]           wbit,
    output logic [1:0][DW-1:0]   rdata
);

    localparam int FW = $clog2(NFLAGS);

    typedef struct packed {
        sem_owner_e [NFLAGS-1:0] owner;
        logic [1:0][NFLAGS-1:0]  req;
        logic [1:0][DW-1:0]      rd;
    } sem_st_t;

    sem_st_t st_d, st_q;

    function automatic sem_owner_e side_code(input int p);
        return (p == 0) ? OWN_LEFT : OWN_RIGHT;
    endfunction

    always_comb begin
        st_d = st_q;
        for (int f = 0; f < NFLAGS; f++) begin
            // Request latches: write 0 sets, write 1 clears
            for (int p = 0; p < 2; p++) begin
                if (wr_en[p] && (idx[p] == FW'(f))) begin
                    st_d.req[p][f] = !wbit[p];
                end
            end
            // Ownership: free grants left first; release hands to a waiting side
            unique case (st_q.owner[f])
                OWN_FREE: begin
                    if (st_d.req[0][f]) begin
                        st_d.owner[f] = OWN_LEFT;
                    end else if (st_d.req[1][f]) begin
                        st_d.owner[f] = OWN_RIGHT;
                    end
                end
                OWN_LEFT: begin
                    if (!st_d.req[0][f]) begin
                        st_d.owner[f] = st_d.req[1][f] ? OWN_RIGHT : OWN_FREE;
                    end
                end
                OWN_RIGHT: begin
                    if (!st_d.req[1][f]) begin
                        st_d.owner[f] = st_d.req[0][f] ? OWN_LEFT : OWN_FREE;
                    end
                end
                default: st_d.owner[f] = OWN_FREE;
            endcase
        end
        // Reads see the state before this cycle's writes, spread over all bits
        for (int p = 0; p < 2; p++) begin
            if (rd_en[p]) begin
                st_d.rd[p] = (st_q.owner[idx[p]] == side_code(p)) ? '0 : '1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata = st_q.rd;

endmodule

// File: rtl/dpm_shared_mem.sv
`timescale 1ns/1ps
module dpm_shared_mem
    import dpm_pkg::*;
#(
    parameter int AW     = 12,
    parameter int DW     = 8,
    parameter int NFLAGS = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          l_ce_n,
    input  logic          l_sem_n,
    input  logic          l_rw_n,
    input  logic          l_oe_n,
    input  logic [AW-1:0] l_addr,
    input  logic [DW-1:0] l_wdata,
    output logic [DW-1:0] l_rdata,
    output logic          l_rdata_en,
    output logic          l_sel_err,
    input  logic          r_ce_n,
    input  logic          r_sem_n,
    input  logic          r_rw_n,
    input  logic          r_oe_n,
    input  logic [AW-1:0] r_addr,
    input  logic [DW-1:0] r_wdata,
    output logic [DW-1:0] r_rdata,
    output logic          r_rdata_en,
    output logic          r_sel_err
);

    localparam int FW = $clog2(NFLAGS);

    logic [1:0]           ce_n, sem_n, rw_n, oe_n;
    logic [1:0][AW-1:0]   addr;
    logic [1:0][DW-1:0]   wdata;
    port_req_t            req [2];
    logic [1:0]           ram_wr, ram_rd, sem_wr, sem_rd;
    logic [1:0][FW-1:0]   sem_idx;
    logic [1:0]           sem_bit;
    logic [1:0][DW-1:0]   ram_q, sem_q, rdata;
    out_ctl_t             out_d, out_q;

    assign ce_n  = {r_ce_n,  l_ce_n};
    assign sem_n = {r_sem_n, l_sem_n};
    assign rw_n  = {r_rw_n,  l_rw_n};
    assign oe_n  = {r_oe_n,  l_oe_n};
    assign addr  = {r_addr,  l_addr};
    assign wdata = {r_wdata, l_wdata};

    for (genvar p = 0; p < 2; p++) begin : g_port
        dpm_port_decode u_dec (
            .ce_n  (ce_n[p]),
            .sem_n (sem_n[p]),
            .rw_n  (rw_n[p]),
            .oe_n  (oe_n[p]),
            .req   (req[p])
        );
        assign ram_wr[p]  = req[p].ram_wr;
        assign ram_rd[p]  = req[p].ram_rd;
        assign sem_wr[p]  = req[p].sem_wr;
        assign sem_rd[p]  = req[p].sem_rd;
        assign sem_idx[p] = addr[p][FW-1:0];
        assign sem_bit[p] = wdata[p][0];
    end

    dpm_ram_core #(.AW(AW), .DW(DW)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (ram_wr),
        .rd_en (ram_rd),
        .addr  (addr),
        .wdata (wdata),
        .rdata (ram_q)
    );

    dpm_sem_bank #(.NFLAGS(NFLAGS), .DW(DW)) u_sem (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (sem_wr),
        .rd_en (sem_rd),
        .idx   (sem_idx),
        .wbit  (sem_bit),
        .rdata (sem_q)
    );

    always_comb begin
        out_d = out_q;
        for (int p = 0; p < 2; p++) begin
            out_d.drive[p]    = req[p].drive;
            out_d.from_sem[p] = req[p].sem_rd;
            out_d.err[p]      = req[p].bad;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    always_comb begin
        for (int p = 0; p < 2; p++) begin
            if (!out_q.drive[p]) begin
                rdata[p] = '0;
            end else if (out_q.from_sem[p]) begin
                rdata[p] = sem_q[p];
            end else begin
                rdata[p] = ram_q[p];
            end
        end
    end

    assign l_rdata    = rdata[0];
    assign r_rdata    = rdata[1];
    assign l_rdata_en = out_q.drive[0];
    assign r_rdata_en = out_q.drive[1];
    assign l_sel_err  = out_q.err[0];
    assign r_sel_err  = out_q.err[1];

endmodule

// File: rtl/dpm_shared_mem_chk.sv
`timescale 1ns/1ps
module dpm_shared_mem_chk #(
    parameter int AW     = 12,
    parameter int DW     = 8,
    parameter int NFLAGS = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          l_ce_n,
    input logic          l_sem_n,
    input logic          l_rw_n,
    input logic          l_oe_n,
    input logic [AW-1:0] l_addr,
    input logic [DW-1:0] l_wdata,
    input logic [DW-1:0] l_rdata,
    input logic          l_rdata_en,
    input logic          l_sel_err,
    input logic          r_ce_n,
    input logic          r_sem_n,
    input logic          r_rw_n,
    input logic          r_oe_n,
    input logic [AW-1:0] r_addr,
    input logic [DW-1:0] r_wdata,
    input logic [DW-1:0] r_rdata,
    input logic          r_rdata_en,
    input logic          r_sel_err
);

    localparam int FW = $clog2(NFLAGS);

    a_r9_left_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_ce_n && !l_sem_n) |=> (l_sel_err && !l_rdata_en));

    a_r9_right_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (!r_ce_n && !r_sem_n) |=> (r_sel_err && !r_rdata_en));

    a_r1_left_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n && l_sem_n) |=> (!l_rdata_en && l_rdata == '0));

    a_r1_right_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce_n && r_sem_n) |=> (!r_rdata_en && r_rdata == '0));

    a_r4_left_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        l_oe_n |=> !l_rdata_en);

    a_r4_right_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        r_oe_n |=> !r_rdata_en);

    a_r6_left_spread: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n && !l_sem_n && l_rw_n && !l_oe_n)
        |=> (l_rdata_en && (l_rdata == '0 || l_rdata == '1)));

    a_r6_right_spread: assert property (@(posedge clk) disable iff (!rst_n)
        (r_ce_n && !r_sem_n && r_rw_n && !r_oe_n)
        |=> (r_rdata_en && (r_rdata == '0 || r_rdata == '1)));

    // R8: a flag is never held by both sides at once
    a_r8_single_holder: assert property (@(posedge clk) disable iff (!rst_n)
        (l_ce_n && !l_sem_n && l_rw_n && !l_oe_n &&
         r_ce_n && !r_sem_n && r_rw_n && !r_oe_n &&
         l_addr[FW-1:0] == r_addr[FW-1:0])
        |=> !(l_rdata == '0 && r_rdata == '0));

endmodule

bind dpm_shared_mem dpm_shared_mem_chk #(.AW(AW), .DW(DW), .NFLAGS(NFLAGS)) chk_i (.*);

// File: tb/dpm_shared_mem_tb.sv
`timescale 1ns/1ps
module dpm_shared_mem_tb_top;

    logic clk = 1'b0;
    logic rst_n;
    always #4 clk = ~clk;

    logic       pce [2];
    logic       psem[2];
    logic       prw [2];
    logic       poe [2];
    logic [11:0] pa [2];
    logic [7:0]  pd [2];

    logic [7:0] l_rdata, r_rdata;
    logic       l_rdata_en, r_rdata_en, l_sel_err, r_sel_err;

    dpm_shared_mem dut_i (
        .clk(clk), .rst_n(rst_n),
        .l_ce_n(pce[0]), .l_sem_n(psem[0]), .l_rw_n(prw[0]), .l_oe_n(poe[0]),
        .l_addr(pa[0]), .l_wdata(pd[0]), .l_rdata(l_rdata),
        .l_rdata_en(l_rdata_en), .l_sel_err(l_sel_err),
        .r_ce_n(pce[1]), .r_sem_n(psem[1]), .r_rw_n(prw[1]), .r_oe_n(poe[1]),
        .r_addr(pa[1]), .r_wdata(pd[1]), .r_rdata(r_rdata),
        .r_rdata_en(r_rdata_en), .r_sel_err(r_sel_err)
    );

    // Behavioural reference state
    logic [7:0] mem_m [4096];
    int         holder_m [8];      // 0 free, 1 left, 2 right
    bit         want_m [2][8];
    int         checks = 0;
    int         fails  = 0;
    bit         done   = 0;

    task automatic set_port(input int p, input logic ce, input logic sem,
                            input logic rw, input logic oe,
                            input logic [11:0] a, input logic [7:0] d);
        pce[p] = ce; psem[p] = sem; prw[p] = rw; poe[p] = oe; pa[p] = a; pd[p] = d;
    endtask

    task automatic idle(input int p);            set_port(p, 1, 1, 1, 1, 12'h0, 8'h0); endtask
    task automatic ram_w(input int p, input logic [11:0] a, input logic [7:0] d);
        set_port(p, 0, 1, 0, 1, a, d); endtask
    task automatic ram_r(input int p, input logic [11:0] a); set_port(p, 0, 1, 1, 0, a, 8'h0); endtask
    task automatic sem_w(input int p, input logic [11:0] a, input logic [7:0] d);
        set_port(p, 1, 0, 0, 1, a, d); endtask
    task automatic sem_r(input int p, input logic [11:0] a); set_port(p, 1, 0, 1, 0, a, 8'h0); endtask

    task automatic flag_write(input int s, input int f, input bit b);
        if (!b) begin
            want_m[s][f] = 1;
            if (holder_m[f] == 0) holder_m[f] = s + 1;
        end else begin
            want_m[s][f] = 0;
            if (holder_m[f] == s + 1) holder_m[f] = want_m[1-s][f] ? (2 - s) : 0;
        end
    endtask

    // One cycle: predict, let one edge pass, compare at the falling edge, update model
    task automatic tick(input string tag);
        logic [7:0] ed [2];
        logic       een[2];
        logic       eer[2];
        logic [9:0] act, expv;
        for (int p = 0; p < 2; p++) begin
            bit rsel, ssel;
            rsel   = !pce[p] && psem[p];
            ssel   = pce[p] && !psem[p];
            eer[p] = !pce[p] && !psem[p];
            een[p] = (rsel || ssel) && prw[p] && !poe[p];
            ed[p]  = 8'h00;
            if (een[p] && rsel) begin
                if (!pce[1-p] && psem[1-p] && !prw[1-p] && pa[1-p] == pa[p]) ed[p] = pd[1-p];
                else ed[p] = mem_m[pa[p]];
            end else if (een[p] && ssel) begin
                ed[p] = (holder_m[pa[p][2:0]] == p + 1) ? 8'h00 : 8'hFF;
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int p = 0; p < 2; p++) begin
            act  = (p == 0) ? {l_rdata_en, l_sel_err, l_rdata} : {r_rdata_en, r_sel_err, r_rdata};
            expv = {een[p], eer[p], ed[p]};
            checks++;
            if (act !== expv) begin
                fails++;
                $display("FAIL %s port%0d actual en=%b err=%b data=%h expected en=%b err=%b data=%h",
                         tag, p, act[9], act[8], act[7:0], expv[9], expv[8], expv[7:0]);
            end
        end
        for (int p = 1; p >= 0; p--) begin
            if (!pce[p] && psem[p] && !prw[p]) mem_m[pa[p]] = pd[p];
        end
        for (int p = 0; p < 2; p++) begin
            if (pce[p] && !psem[p] && !prw[p]) flag_write(p, int'(pa[p][2:0]), pd[p][0]);
        end
        idle(0);
        idle(1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R12 actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        for (int f = 0; f < 8; f++) begin
            holder_m[f] = 0; want_m[0][f] = 0; want_m[1][f] = 0;
        end
        idle(0); idle(1);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state, every flag free
        tick("R12");
        sem_r(0, 12'h0); sem_r(1, 12'h7); tick("R12");

        // R2, R3: writes at the extremes and in the middle, then reads
        ram_w(0, 12'h000, 8'hA5); ram_w(1, 12'hFFF, 8'h3C); tick("R2");
        ram_w(0, 12'h005, 8'h11); ram_w(1, 12'h800, 8'hC3); tick("R2");
        ram_r(0, 12'hFFF); ram_r(1, 12'h000); tick("R3");
        ram_r(0, 12'h800); ram_r(1, 12'h005); tick("R3");

        // R1: standby with a write pattern on the pins leaves the byte alone
        set_port(0, 1, 1, 0, 0, 12'h005, 8'hEE); tick("R1");
        ram_r(1, 12'h005); tick("R1");

        // R4: read with output enable off
        set_port(0, 0, 1, 1, 1, 12'h005, 8'h0); tick("R4");

        // R9: both selects low; no RAM write, no flag claim
        set_port(0, 0, 0, 0, 1, 12'h005, 8'h00); set_port(1, 0, 0, 1, 0, 12'h000, 8'h0); tick("R9");
        ram_r(0, 12'h005); sem_r(1, 12'h005); tick("R9");
        sem_r(0, 12'h005); tick("R9");

        // R5: claim flag 3 through upper address bits, other data bits set
        sem_w(0, 12'hFF3, 8'hFE); tick("R5");
        sem_r(0, 12'h003); sem_r(1, 12'hAB3); tick("R5");
        sem_w(1, 12'h003, 8'h01); tick("R5");
        sem_r(0, 12'h003); tick("R5");
        sem_w(0, 12'h003, 8'h01); tick("R5");
        sem_r(0, 12'h003); sem_r(1, 12'h003); tick("R5");

        // R6: read in the same cycle as a claim sees the old state
        sem_w(0, 12'h004, 8'h00); sem_r(1, 12'h004); tick("R6");
        sem_r(0, 12'h004); tick("R6");
        sem_w(0, 12'h004, 8'hFF); tick("R6");

        // R7: queued claim handed over on release
        sem_w(0, 12'h002, 8'h00); tick("R7");
        sem_w(1, 12'h002, 8'h00); tick("R7");
        sem_r(1, 12'h002); tick("R7");
        sem_w(0, 12'h002, 8'h01); tick("R7");
        sem_r(0, 12'h002); sem_r(1, 12'h002); tick("R7");
        sem_w(0, 12'h002, 8'h00); tick("R7");
        sem_w(0, 12'h002, 8'h01); tick("R7");
        sem_w(1, 12'h002, 8'h01); tick("R7");
        sem_r(0, 12'h002); sem_r(1, 12'h002); tick("R7");

        // R8: simultaneous claim of a free flag
        sem_w(0, 12'h006, 8'h00); sem_w(1, 12'h006, 8'h00); tick("R8");
        sem_r(0, 12'h006); sem_r(1, 12'h006); tick("R8");
        sem_w(0, 12'h006, 8'h01); tick("R8");
        sem_r(0, 12'h006); sem_r(1, 12'h006); tick("R8");

        // R10: same-address write race
        ram_w(0, 12'h100, 8'h77); ram_w(1, 12'h100, 8'h88); tick("R10");
        ram_r(0, 12'h100); ram_r(1, 12'h100); tick("R10");

        // R11: forwarding in both directions
        ram_w(0, 12'h200, 8'h5A); ram_r(1, 12'h200); tick("R11");
        ram_w(1, 12'h200, 8'hA6); ram_r(0, 12'h200); tick("R11");
        ram_w(1, 12'h201, 8'h12); ram_r(0, 12'h200); tick("R11");

        // Mixed traffic over a preloaded window
        for (int i = 0; i < 16; i++) begin
            ram_w(0, 12'(i), 8'(i * 13 + 7)); tick("R2");
        end
        seed = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            for (int p = 0; p < 2; p++) begin
                int op;
                logic [11:0] a;
                logic [7:0]  d;
                seed = seed * 1664525 + 1013904223;
                op = int'(seed[31:28] % 7);
                a  = {seed[23:16], seed[3:0]} & 12'h00F;
                d  = seed[15:8];
                case (op)
                    0: idle(p);
                    1: ram_w(p, a, d);
                    2: ram_r(p, a);
                    3: sem_w(p, {seed[27:19], seed[2:0]}, d);
                    4: sem_r(p, {seed[27:19], seed[2:0]});
                    5: set_port(p, 0, 0, seed[4], seed[5], a, d);
                    default: set_port(p, 0, 1, 1, 1, a, d);
                endcase
            end
            tick("R3");
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule